// File: doc/BRIEF.md
# Clock Pointer Table with Reference Counting

Per-byte access metadata has room only for a short clock field, yet race checks compare full-width logical clocks. This block resolves that mismatch. It keeps a small table in which each entry holds a full logical clock and a count of the metadata fields that still point at it. The short field stores a pointer into this table. Pointer code zero is reserved and means "never accessed", which leaves codes 1 to 2**PTR_W-1 as table entries.

When synchronization advances the local clock, the core requests a new entry. The block returns the lowest-numbered free pointer combinationally, in the same cycle, and writes the clock on the next edge. The entry starts with a count of one, which stands for the core's own hold on the new clock. Metadata writes increment the count of the stored pointer. Overwrites and evictions decrement the count of the pointer they drop. An entry whose count reaches zero is free and can be handed out again, so the pointers held in the cache need not refer to consecutive clocks.

A lookup port maps a pointer back to its clock. When every entry is held, the block flags that the table is full. Allocation is then refused, and the surrounding logic must flush cached metadata.

Top module: `clk_ptr_table`

## Requirements
- R1: While reset is asserted and after it is released, every entry is free. `full_o` and `err_o` are low, a lookup of any pointer returns `lk_valid_o` low, and `alloc_ptr_o` shows pointer 1.
- R2: When `alloc_req_i` is high and an entry is free, `alloc_ok_o` is high in the same cycle and `alloc_ptr_o` holds the lowest-numbered free pointer, which is never 0.
- R3: After the edge that accepts an allocation, the entry holds `alloc_clk_i` with a count of exactly one. A lookup of that pointer returns `lk_valid_o` high and the stored clock on `lk_clk_o`.
- R4: A lookup of pointer 0, or of a free entry, returns `lk_valid_o` low with `lk_clk_o` all zeros.
- R5: An increment raises an entry's count by one and a decrement lowers it by one. An entry whose count reaches zero becomes free and can be allocated again.
- R6: An increment and a decrement that target the same entry in the same cycle leave its count unchanged.
- R7: A decrement of an entry whose count is already zero, with no increment of that entry in the same cycle, leaves the count at zero and drives `err_o` high for exactly the following cycle.
- R8: While all entries are held, `full_o` is high and `alloc_ok_o` stays low under a request. A refused request changes no entry.
- R9: An increment or decrement aimed at pointer 0 changes no entry and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_req_i | input | 1 | Request a new entry for a new clock |
| alloc_clk_i | input | CLK_W | Clock value to store on allocation |
| alloc_ok_o | output | 1 | Allocation accepted this cycle |
| alloc_ptr_o | output | PTR_W | Lowest free pointer (the allocated pointer when accepted) |
| full_o | output | 1 | No free entry; a metadata flush is required |
| lk_ptr_i | input | PTR_W | Pointer to look up |
| lk_valid_o | output | 1 | Lookup pointer names a held entry |
| lk_clk_o | output | CLK_W | Clock of the looked-up entry, zero when invalid |
| inc_i | input | 1 | Increment request |
| inc_ptr_i | input | PTR_W | Pointer to increment |
| dec_i | input | 1 | Decrement request |
| dec_ptr_i | input | PTR_W | Pointer to decrement |
| err_o | output | 1 | A decrement hit a zero count in the previous cycle |

## Verification
Allocation is exercised in three situations: from an empty table, after a hole opens below the highest held entry, and with every entry held. These separate a lowest-free search from a simple next-pointer counter, and show whether refusal is honoured. Reference counts cannot be read directly. They are inferred by sending a known number of decrements and watching when lookups turn invalid and when `err_o` fires. This reveals whether counts start at one, whether a paired increment and decrement cancel, and whether a decrement stops at zero. Traffic aimed at pointer 0 is checked for the absence of any error or state change.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  typedef struct packed {
    logic alloc;
    logic inc;
    logic dec;
  } ent_op_t;
endpackage

// File: rtl/cpt_free_finder.sv
module cpt_free_finder #(
  parameter int unsigned PTR_W = 6,
  localparam int unsigned N_CODES = 2 ** PTR_W
) (
  input  logic [N_CODES-1:0] free_i,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               any_o
);
  // code 0 is reserved and never searched
  always_comb begin
    ptr_o = '0;
    any_o = 1'b0;
    for (int i = N_CODES - 1; i >= 1; i--) begin
      if (free_i[i]) begin
        ptr_o = PTR_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpt_entry.sv
module cpt_entry
  import cpt_pkg::*;
#(
  parameter int unsigned CLK_W = 64,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ent_op_t          op_i,
  input  logic [CLK_W-1:0] clk_val_i,
  output logic [CLK_W-1:0] clk_val_o,
  output logic             free_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CLK_W-1:0] clk_q;

  always_comb begin
    cnt_d = cnt_q;
    if (op_i.alloc) cnt_d = CntOne;
    else if (op_i.inc && !op_i.dec && cnt_q != CntMax) cnt_d = cnt_q + CntOne;
    else if (op_i.dec && !op_i.inc && cnt_q != '0) cnt_d = cnt_q - CntOne;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (op_i.alloc) clk_q <= clk_val_i;
    end
  end

  assign clk_val_o   = clk_q;
  assign free_o      = (cnt_q == '0);
  assign underflow_o = op_i.dec && !op_i.inc && (cnt_q == '0);

  a_r3_alloc_count_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.alloc |=> (cnt_q == CntOne));

  a_r6_cancel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.inc && op_i.dec && !op_i.alloc) |=> $stable(cnt_q));

  a_r5_dec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.dec && !op_i.inc && !op_i.alloc && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CntOne));
endmodule

// File: rtl/clk_ptr_table.sv
module clk_ptr_table
  import cpt_pkg::*;
#(
  parameter int unsigned PTR_W = 6,
  parameter int unsigned CLK_W = 64,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_req_i,
  input  logic [CLK_W-1:0] alloc_clk_i,
  output logic             alloc_ok_o,
  output logic [PTR_W-1:0] alloc_ptr_o,
  output logic             full_o,
  input  logic [PTR_W-1:0] lk_ptr_i,
  output logic             lk_valid_o,
  output logic [CLK_W-1:0] lk_clk_o,
  input  logic             inc_i,
  input  logic [PTR_W-1:0] inc_ptr_i,
  input  logic             dec_i,
  input  logic [PTR_W-1:0] dec_ptr_i,
  output logic             err_o
);
  localparam int unsigned NCodes = 2 ** PTR_W;

  logic [NCodes-1:0] free_vec;
  logic [NCodes-1:0] uf_vec;
  logic [CLK_W-1:0]  clk_arr [NCodes];
  logic              any_free;
  logic              err_q;

  // reserved code 0: never free, never holds a clock
  assign free_vec[0] = 1'b0;
  assign uf_vec[0]   = 1'b0;
  assign clk_arr[0]  = '0;

  for (genvar g = 1; g < NCodes; g++) begin : g_ent
    ent_op_t op;
    assign op.alloc = alloc_ok_o && (alloc_ptr_o == PTR_W'(g));
    assign op.inc   = inc_i && (inc_ptr_i == PTR_W'(g));
    assign op.dec   = dec_i && (dec_ptr_i == PTR_W'(g));

    cpt_entry #(
      .CLK_W(CLK_W),
      .CNT_W(CNT_W)
    ) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .op_i       (op),
      .clk_val_i  (alloc_clk_i),
      .clk_val_o  (clk_arr[g]),
      .free_o     (free_vec[g]),
      .underflow_o(uf_vec[g])
    );
  end

  cpt_free_finder #(.PTR_W(PTR_W)) u_find (
    .free_i(free_vec),
    .ptr_o (alloc_ptr_o),
    .any_o (any_free)
  );

  assign full_o     = !any_free;
  assign alloc_ok_o = alloc_req_i && any_free;

  assign lk_valid_o = (lk_ptr_i != '0) && !free_vec[lk_ptr_i];
  assign lk_clk_o   = lk_valid_o ? clk_arr[lk_ptr_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= |uf_vec;
  end
  assign err_o = err_q;

  a_r2_pick_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ok_o |-> ((alloc_ptr_o != '0) && free_vec[alloc_ptr_o]));

  a_r7_err_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|uf_vec) |=> err_o);

  a_r4_reserved_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_ptr_i == '0) |-> (!lk_valid_o && lk_clk_o == '0));

  a_r8_full_no_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (free_vec == '0));
endmodule

// File: tb/clk_ptr_table_tb.sv
module clk_ptr_table_tb;
  localparam int PTR_W = 6;
  localparam int CLK_W = 64;
  localparam int NENT  = 2 ** PTR_W - 1;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             alloc_req;
  logic [CLK_W-1:0] alloc_clk;
  logic             alloc_ok;
  logic [PTR_W-1:0] alloc_ptr;
  logic             full;
  logic [PTR_W-1:0] lk_ptr;
  logic             lk_valid;
  logic [CLK_W-1:0] lk_clk;
  logic             inc;
  logic [PTR_W-1:0] inc_ptr;
  logic             dec;
  logic [PTR_W-1:0] dec_ptr;
  logic             err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_ptr_table #(.PTR_W(PTR_W), .CLK_W(CLK_W), .CNT_W(24)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_req_i(alloc_req), .alloc_clk_i(alloc_clk),
    .alloc_ok_o(alloc_ok), .alloc_ptr_o(alloc_ptr), .full_o(full),
    .lk_ptr_i(lk_ptr), .lk_valid_o(lk_valid), .lk_clk_o(lk_clk),
    .inc_i(inc), .inc_ptr_i(inc_ptr), .dec_i(dec), .dec_ptr_i(dec_ptr),
    .err_o(err)
  );

  typedef struct packed {
    logic             alloc;
    logic [CLK_W-1:0] aclk;
    logic             inc;
    logic [PTR_W-1:0] iptr;
    logic             dec;
    logic [PTR_W-1:0] dptr;
    logic [PTR_W-1:0] lptr;
    logic             e_ok;
    logic [PTR_W-1:0] e_ptr;
    logic             e_lv;
    logic [CLK_W-1:0] e_lclk;
    logic             e_err;
  } vec_t;

  // inputs driven this cycle; expectations sampled before the edge
  localparam vec_t VECS [12] = '{
    '{1'b1, 64'h100, 1'b0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b1, 6'd1, 1'b0, 64'h0,   1'b0}, // R2 R4
    '{1'b1, 64'h200, 1'b0, 6'd0, 1'b0, 6'd0, 6'd1, 1'b1, 6'd2, 1'b1, 64'h100, 1'b0}, // R2 R3
    '{1'b1, 64'h300, 1'b0, 6'd0, 1'b0, 6'd0, 6'd2, 1'b1, 6'd3, 1'b1, 64'h200, 1'b0}, // R3
    '{1'b0, 64'h0,   1'b1, 6'd1, 1'b0, 6'd0, 6'd3, 1'b0, 6'd0, 1'b1, 64'h300, 1'b0}, // R5 inc 1 -> 2
    '{1'b0, 64'h0,   1'b0, 6'd0, 1'b1, 6'd2, 6'd1, 1'b0, 6'd0, 1'b1, 64'h100, 1'b0}, // R5 free 2
    '{1'b1, 64'h400, 1'b0, 6'd0, 1'b0, 6'd0, 6'd2, 1'b1, 6'd2, 1'b0, 64'h0,   1'b0}, // R5 R4 reuse 2
    '{1'b0, 64'h0,   1'b1, 6'd1, 1'b1, 6'd1, 6'd2, 1'b0, 6'd0, 1'b1, 64'h400, 1'b0}, // R6 cancel
    '{1'b0, 64'h0,   1'b0, 6'd0, 1'b1, 6'd1, 6'd1, 1'b0, 6'd0, 1'b1, 64'h100, 1'b0}, // R6 2 -> 1
    '{1'b0, 64'h0,   1'b0, 6'd0, 1'b1, 6'd1, 6'd1, 1'b0, 6'd0, 1'b1, 64'h100, 1'b0}, // R5 1 -> 0
    '{1'b0, 64'h0,   1'b0, 6'd0, 1'b1, 6'd1, 6'd1, 1'b0, 6'd0, 1'b0, 64'h0,   1'b0}, // R7 underflow
    '{1'b0, 64'h0,   1'b1, 6'd0, 1'b1, 6'd0, 6'd0, 1'b0, 6'd0, 1'b0, 64'h0,   1'b1}, // R7 err, R9 code 0
    '{1'b1, 64'h500, 1'b0, 6'd0, 1'b0, 6'd0, 6'd3, 1'b1, 6'd1, 1'b1, 64'h300, 1'b0}  // R9 R7 no err
  };

  task automatic check(input bit ok, input string req, input logic [CLK_W-1:0] act,
                       input logic [CLK_W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_req = 1'b0; alloc_clk = '0; inc = 1'b0; inc_ptr = '0;
    dec = 1'b0; dec_ptr = '0; lk_ptr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    idle();
    #1;
    check(!full && !err && !lk_valid, "R1 reset flags", {full, err, lk_valid}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    rst_ni = 1'b0;
    idle();
    do_reset();
    // R1: state after release
    lk_ptr = 6'd1;
    #1;
    check(!lk_valid, "R1 lookup invalid", lk_valid, 0);
    check(alloc_ptr == 6'd1, "R1 first free", alloc_ptr, 1);
    check(!err && !full, "R1 flags low", {err, full}, 0);

    // vector walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      alloc_req = VECS[i].alloc; alloc_clk = VECS[i].aclk;
      inc = VECS[i].inc; inc_ptr = VECS[i].iptr;
      dec = VECS[i].dec; dec_ptr = VECS[i].dptr;
      lk_ptr = VECS[i].lptr;
      #1;
      if (VECS[i].alloc) begin
        check(alloc_ok == VECS[i].e_ok, $sformatf("R2 ok vec%0d", i), alloc_ok, VECS[i].e_ok);
        check(alloc_ptr == VECS[i].e_ptr, $sformatf("R2 ptr vec%0d", i), alloc_ptr, VECS[i].e_ptr);
      end
      check(lk_valid == VECS[i].e_lv, $sformatf("R3/R4 valid vec%0d", i), lk_valid, VECS[i].e_lv);
      check(lk_clk == VECS[i].e_lclk, $sformatf("R3/R4 clock vec%0d", i), lk_clk, VECS[i].e_lclk);
      check(err == VECS[i].e_err, $sformatf("R7/R9 err vec%0d", i), err, VECS[i].e_err);
    end

    // R8: fill the whole table
    do_reset();
    for (int k = 1; k <= NENT; k++) begin
      @(negedge clk);
      idle();
      alloc_req = 1'b1; alloc_clk = 64'h1000 + 64'(k);
      #1;
      check(alloc_ok && alloc_ptr == PTR_W'(k), "R2 fill order", alloc_ptr, k);
    end
    @(negedge clk);
    idle();
    alloc_req = 1'b1; alloc_clk = 64'hdead;
    lk_ptr = PTR_W'(NENT);
    #1;
    check(full, "R8 full", full, 1);
    check(!alloc_ok, "R8 refused", alloc_ok, 0);
    check(lk_valid && lk_clk == 64'h1000 + 64'(NENT), "R3 last clock", lk_clk, 64'h1000 + 64'(NENT));
    @(negedge clk);
    alloc_req = 1'b0;
    lk_ptr = 6'd1;
    #1;
    check(lk_clk == 64'h1001, "R8 refused write no effect", lk_clk, 64'h1001);
    check(full, "R8 still full", full, 1);
    dec = 1'b1; dec_ptr = 6'd5;
    @(negedge clk);
    dec = 1'b0;
    lk_ptr = 6'd5;
    #1;
    check(!full, "R5 full clears", full, 0);
    check(alloc_ptr == 6'd5, "R5 hole reused", alloc_ptr, 5);
    check(!lk_valid, "R3 count was one", lk_valid, 0);
    check(!err, "R3 single dec no err", err, 0);
    dec = 1'b1; dec_ptr = 6'd5;
    @(negedge clk);
    dec = 1'b0;
    #1;
    check(err, "R7 err pulse", err, 1);
    @(negedge clk);
    #1;
    check(!err, "R7 pulse one cycle", err, 0);
    check(!lk_valid, "R7 count stays zero", lk_valid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule